// File: doc/BRIEF.md
# Interrupt Service Latency Histogram

This block records how late each compare event is actually serviced. When the handler begins, the surrounding logic presents two 16-bit timestamps and pulses a service strobe:

- the compare value that had been armed;
- the free-running counter value captured at the start of service.

The block subtracts the armed value from the captured value. The subtraction wraps modulo the timestamp width, so a counter that has rolled over still gives the right latency. The result is classified against a fixed ladder of non-uniform limits, and the matching bin counter advances by one.

There are eight bounded bins and one catch-all bin for anything beyond the largest limit. A host can read any bin through a combinational read port. A clear input empties the whole histogram. Counters stop at their maximum value instead of wrapping, so a long-running histogram never reports a small count for a busy bin.

Top module: `latency_histogram`

## Requirements
- R1: Latency is `serviceStamp - armedStamp` taken modulo 2^TS_W, with TS_W = 16 by default. For example, armed 65530 with captured 3 gives latency 9.
- R2: The bounded bins 0 to 7 have inclusive upper limits 1, 2, 5, 10, 20, 50, 100 and 1000, in that index order. A sample lands in the lowest-index bin whose limit is greater than or equal to its latency, so latency 0 lands in bin 0 and latency 6 lands in bin 3.
- R3: A latency greater than 1000 lands in the catch-all bin, index 8. This includes wrapped latencies such as 65535.
- R4: Each cycle with `serviceStrobe` high and `clearReq` low adds one to exactly one bin, unless that bin is saturated. No bin changes in a cycle with neither strobe nor clear, and the new count is visible on `rdData` after the clock edge that sampled the strobe.
- R5: A bin counter is CNT_W bits wide (32 by default). A bin at 2^CNT_W-1 stays there when further samples land in it.
- R6: `clearReq` high at a clock edge sets all nine bins to zero. It takes priority over a `serviceStrobe` in the same cycle, which is then not counted.
- R7: After the asynchronous active-low reset `rstN`, all nine bins read zero.
- R8: `rdData` combinationally shows the count of bin `rdIdx` for indices 0 to 8. Any `rdIdx` of 9 or more reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armedStamp | input | TS_W | Compare value that was armed |
| serviceStamp | input | TS_W | Counter value captured when service began |
| serviceStrobe | input | 1 | One sample per cycle in which it is high |
| clearReq | input | 1 | Zero all bins; wins over a strobe |
| rdIdx | input | 4 | Bin index to read |
| rdData | output | CNT_W | Count of the selected bin, zero when out of range |

## Verification
The bench keeps TS_W at 16, so the modular wrap of the timestamp difference and latencies near 65535 are exercised at their real width. It shrinks CNT_W to 4, which brings saturation within reach after fifteen samples into one bin. That lets the bench check hold-at-maximum alongside every limit edge (n and n+1 for each threshold). The clear-versus-strobe collision, out-of-range read indices and a long pseudo-random stream are checked against the same model on every clock.

// File: rtl/lat_hist_pkg.sv
package lat_hist_pkg;

  localparam int NUM_BOUNDED = 8;
  localparam int NUM_BINS    = NUM_BOUNDED + 1;
  localparam int BIN_IDX_W   = $clog2(NUM_BINS);

  // Inclusive upper latency limit of each bounded bin, lowest index first.
  function automatic logic [31:0] binLimit(input int idx);
    case (idx)
      0:       binLimit = 32'd1;
      1:       binLimit = 32'd2;
      2:       binLimit = 32'd5;
      3:       binLimit = 32'd10;
      4:       binLimit = 32'd20;
      5:       binLimit = 32'd50;
      6:       binLimit = 32'd100;
      default: binLimit = 32'd1000;
    endcase
  endfunction

  // Strobes from classification control to the counter bank.
  typedef struct packed {
    logic                 clrAll;
    logic                 bump;
    logic [BIN_IDX_W-1:0] binSel;
  } histCmd_t;

endpackage

// File: rtl/lat_hist_ctrl.sv
module lat_hist_ctrl
  import lat_hist_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic [TS_W-1:0] armedStamp,
  input  logic [TS_W-1:0] serviceStamp,
  input  logic            serviceStrobe,
  input  logic            clearReq,
  output histCmd_t        cmd
);

  logic [TS_W-1:0]      latency;
  logic [31:0]          latWide;
  logic [BIN_IDX_W-1:0] chosen;

  // Wraps naturally at TS_W bits (R1).
  assign latency = serviceStamp - armedStamp;
  assign latWide = 32'(latency);

  // Scan downward so the lowest matching index is the last one written (R2, R3).
  always_comb begin
    chosen = BIN_IDX_W'(NUM_BOUNDED);
    for (int i = NUM_BOUNDED - 1; i >= 0; i--) begin
      if (latWide <= binLimit(i)) chosen = BIN_IDX_W'(i);
    end
  end

  always_comb begin
    cmd.clrAll = clearReq;
    cmd.bump   = serviceStrobe & ~clearReq;
    cmd.binSel = chosen;
  end

endmodule

// File: rtl/lat_hist_bank.sv
module lat_hist_bank
  import lat_hist_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  histCmd_t             cmd,
  input  logic [BIN_IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0]     rdData,
  output logic [CNT_W-1:0]     binCount [NUM_BINS]
);

  localparam logic [CNT_W-1:0] SAT_VAL = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM_BINS; g++) begin : gBin
    logic hit;
    assign hit = cmd.bump && (cmd.binSel == BIN_IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        binCount[g] <= '0;
      end else if (cmd.clrAll) begin
        binCount[g] <= '0;
      end else if (hit && (binCount[g] != SAT_VAL)) begin
        binCount[g] <= binCount[g] + 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdIdx < BIN_IDX_W'(NUM_BINS)) rdData = binCount[rdIdx];
  end

endmodule

// File: rtl/latency_histogram.sv
module latency_histogram
  import lat_hist_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TS_W-1:0]      armedStamp,
  input  logic [TS_W-1:0]      serviceStamp,
  input  logic                 serviceStrobe,
  input  logic                 clearReq,
  input  logic [BIN_IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0]     rdData
);

  histCmd_t   cmd;
  logic [CNT_W-1:0] binCount [NUM_BINS];

  lat_hist_ctrl #(.TS_W(TS_W)) u_ctrl (
    .armedStamp   (armedStamp),
    .serviceStamp (serviceStamp),
    .serviceStrobe(serviceStrobe),
    .clearReq     (clearReq),
    .cmd          (cmd)
  );

  lat_hist_bank #(.CNT_W(CNT_W)) u_bank (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .rdIdx   (rdIdx),
    .rdData  (rdData),
    .binCount(binCount)
  );

endmodule

// File: rtl/lat_hist_checker.sv
module lat_hist_checker
  import lat_hist_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 serviceStrobe,
  input logic                 clearReq,
  input logic [BIN_IDX_W-1:0] rdIdx,
  input logic [CNT_W-1:0]     rdData,
  input logic [CNT_W-1:0]     binCount [NUM_BINS]
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0]    prevBin [NUM_BINS];
  logic                prevValid, prevStrobe, prevClear;
  logic [NUM_BINS-1:0] moved, isZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid  <= 1'b0;
      prevStrobe <= 1'b0;
      prevClear  <= 1'b0;
      for (int i = 0; i < NUM_BINS; i++) prevBin[i] <= '0;
    end else begin
      prevValid  <= 1'b1;
      prevStrobe <= serviceStrobe;
      prevClear  <= clearReq;
      for (int i = 0; i < NUM_BINS; i++) prevBin[i] <= binCount[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_BINS; i++) begin
      moved[i]  = (binCount[i] != prevBin[i]);
      isZero[i] = (binCount[i] == '0);
    end
  end

  assert_reset_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    !prevValid |-> (&isZero));

  assert_single_bump_R4: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevStrobe && !prevClear) |-> ($countones(moved) <= 1));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && !prevStrobe && !prevClear) |-> (moved == '0));

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevClear) |-> (&isZero));

  assert_read_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx >= BIN_IDX_W'(NUM_BINS)) |-> (rdData == '0));

  for (genvar g = 0; g < NUM_BINS; g++) begin : gChk
    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rstN)
      (prevValid && !prevClear && prevBin[g] == TOP) |-> (binCount[g] == TOP));
    assert_no_decrease_R4: assert property (@(posedge clk) disable iff (!rstN)
      (prevValid && !prevClear) |-> (binCount[g] >= prevBin[g]));
  end

endmodule

bind latency_histogram lat_hist_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/latency_histogram_tb.sv
module latency_histogram_tb;

  localparam int TS_W  = 16;
  localparam int CNT_W = 4;
  localparam int NB    = 9;
  localparam int SATV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [TS_W-1:0]  armedStamp = '0;
  logic [TS_W-1:0]  serviceStamp = '0;
  logic             serviceStrobe = 1'b0;
  logic             clearReq = 1'b0;
  logic [3:0]       rdIdx = '0;
  logic [CNT_W-1:0] rdData;

  int model [NB];
  int limits [8] = '{1, 2, 5, 10, 20, 50, 100, 1000};
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  latency_histogram #(.TS_W(TS_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .armedStamp(armedStamp), .serviceStamp(serviceStamp),
    .serviceStrobe(serviceStrobe), .clearReq(clearReq), .rdIdx(rdIdx), .rdData(rdData)
  );

  function automatic int expBin(int arm, int samp);
    int lat = (samp - arm) & 16'hFFFF;
    for (int i = 0; i < 8; i++) if (lat <= limits[i]) return i;
    return 8;
  endfunction

  function automatic int readExp(int idx);
    if (idx >= NB) return 0;
    return model[idx];
  endfunction

  task automatic check(string req, int exp);
    checks++;
    if (int'(rdData) != exp) begin
      errors++;
      $display("FAIL %s rdIdx=%0d actual=%0d expected=%0d", req, rdIdx, rdData, exp);
    end
  endtask

  // Drive at negedge, update model after posedge, check at next negedge.
  task automatic step(string req, int arm, int samp, bit strobe, bit clr, int rd);
    armedStamp    = TS_W'(arm);
    serviceStamp  = TS_W'(samp);
    serviceStrobe = strobe;
    clearReq      = clr;
    rdIdx         = 4'(rd);
    @(posedge clk);
    if (clr) begin
      for (int i = 0; i < NB; i++) model[i] = 0;
    end else if (strobe) begin
      int b = expBin(arm, samp);
      if (model[b] < SATV) model[b]++;
    end
    @(negedge clk);
    check(req, readExp(rd));
  endtask

  task automatic hit(string req, int arm, int lat);
    int samp = (arm + lat) & 16'hFFFF;
    step(req, arm, samp, 1'b1, 1'b0, expBin(arm, samp));
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < NB; i++) step(req, 0, 0, 1'b0, 1'b0, i);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    // R7: everything zero right out of reset
    for (int i = 0; i < NB; i++) begin
      rdIdx = 4'(i);
      #1;
      check("R7", 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R8: out-of-range indices read zero
    step("R8", 0, 0, 1'b0, 1'b0, 12);
    step("R8", 0, 0, 1'b0, 1'b0, 9);

    // R2: each limit and the value just past it
    hit("R2", 100, 0);
    for (int i = 0; i < 8; i++) begin
      hit("R2", 300 + i, limits[i]);
      if (i < 7) hit("R2", 300 + i, limits[i] + 1);
    end
    // R3: beyond the last limit and far beyond
    hit("R3", 7, 1001);
    hit("R3", 10, 65535);
    // R1: wrapped subtraction gives a small latency (9 -> bin 3)
    step("R1", 65530, 3, 1'b1, 1'b0, 3);
    step("R1", 65535, 0, 1'b1, 1'b0, 0);
    // R4: idle cycles leave every bin as it was
    sweep("R4");

    // R5: push bin 2 far past saturation
    for (int k = 0; k < 20; k++) hit("R5", 40, 4);
    step("R5", 0, 0, 1'b0, 1'b0, 2);

    // R6: clear together with a strobe; strobe is dropped
    step("R6", 0, 4, 1'b1, 1'b1, 2);
    sweep("R6");

    // R2/R4: pseudo-random stream, reading random bins
    for (int k = 0; k < 300; k++) begin
      int a = $urandom_range(0, 65535);
      int l = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 65535) : $urandom_range(0, 1200);
      bit s = ($urandom_range(0, 3) != 0);
      bit c = ($urandom_range(0, 60) == 0);
      step("R4", a, (a + l) & 16'hFFFF, s, c, $urandom_range(0, 10));
    end
    sweep("R4");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule